// File: doc/BRIEF.md
# Tuner Control Serial Register Bank

This block is the control port of a broadcast tuner. It is a slave on a two-wire I2C-compatible bus. SCL and SDA are sampled in a fast system clock and pass through synchronizers. The bus conditions START, repeated START and STOP are recognised by watching SDA move while SCL is high. After a START, the block compares the first byte with its 7-bit device address, one bit of which comes from a strap input. On a write it takes a register pointer, then stores data bytes at successive pointer values. On a read, which follows a repeated START, it returns successive registers MSB first until the master declines a byte.

The block holds thirteen read/write control registers, which are visible as a flat output. Three further pointer values return read-only status bytes taken from an input. Two enables are decoded from the stored fields:
- A crystal-oscillator enable, derived from the synthesizer and reference-buffer shutdown bits.
- A main-bias enable, which stays on while any powered block, the VCO band field or the DC-offset mode field is active.

The serial engine is a single enumerated state machine with these states:
- Idle `S_IDLE`.
- Address byte `S_ADDR`, then address acknowledge `S_ACK_ADR`.
- Pointer byte `S_PTR`, then pointer acknowledge `S_ACK_PTR`.
- Write byte `S_WR`, then write acknowledge `S_ACK_WR`.
- Read byte `S_RD`, then master acknowledge `S_MACK`.

Its transitions are these:
- START from any state goes to `S_ADDR`, and STOP from any state goes to `S_IDLE`.
- At the eighth-bit SCL fall, `S_ADDR` goes to `S_ACK_ADR` on a match and to `S_IDLE` on a mismatch.
- `S_ACK_ADR` goes to `S_RD` for a read and to `S_PTR` for a write.
- `S_PTR` goes to `S_ACK_PTR`, which goes to `S_WR`.
- `S_WR` goes to `S_ACK_WR`, which goes back to `S_WR`.
- `S_RD` goes to `S_MACK` after eight bits. `S_MACK` goes back to `S_RD` on a master ACK and to `S_IDLE` on a NACK.

Top module: `tuner_i2c_regbank`

## Requirements
- R1: The device address byte is {1,1,0,0,0,addr_strap,0,RW} with bit 7 sent first and RW=0 meaning write. A matching byte is acknowledged by driving SDA low for the whole ninth SCL clock.
- R2: If the address does not match, there is no acknowledge. All following bytes are ignored until the next START, and no register changes.
- R3: In a write, the byte after the address is the pointer, of which the low 4 bits are used. Each following data byte is stored at the pointer, the pointer then advances by one, and every such byte is acknowledged.
- R4: In a read, a repeated START with RW=1 returns the byte at the pointer, MSB first, and advances the pointer. A master ACK gives the next byte. A master NACK ends the read with SDA released.
- R5: Pointers 0x00 to 0x0C are read/write registers. Register k appears on regs_flat[8k+7:8k]. Pointers 0x0D, 0x0E and 0x0F read ro_status bytes 0, 1 and 2, where byte j is ro_status[8j+7:8j]. Writes to those pointers are acknowledged and discarded.
- R6: The pointer wraps from 0x0F to 0x00 on both reads and writes.
- R7: A STOP at any point returns the block to idle with SDA released. A partly received data byte is not stored.
- R8: After reset, all registers are 0x00, SDA is released, xtal_en is 1 and bias_en is 1.
- R9: xtal_en is 0 only when register 0x08 bit 4 (synthesizer shutdown) and bit 5 (reference-buffer shutdown) are both 1. A value of 1 means disabled.
- R10: bias_en is 0 only when all three of these hold: register 0x08 bits 5:0 are all 1, register 0x09 bits 7:6 (VCO band, where 00 means VCO off) are 00, and register 0x0B bits 1:0 (DC-offset mode) are 00.
- R11: sda_oe changes only while the synchronized SCL is low, and register contents change only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| addr_strap | input | 1 | Strapped bit 1 of the device address |
| ro_status | input | 24 | Three read-only status bytes |
| regs_flat | output | 104 | Thirteen control registers, register k at bits 8k+7:8k |
| xtal_en | output | 1 | Crystal-oscillator enable |
| bias_en | output | 1 | Main-bias enable |

## Verification
The transfer engine is exercised with these patterns, each separating a different fault:
- A table of single-register writes, each followed by a single-register read. This separates storage faults from read-path faults.
- Multi-byte bursts that cross the end of the writable range and the 0x0F-to-0x00 wrap. These expose pointer-increment faults.
- Reads of the status pointers and writes to them. These show whether read-only bytes are correctly discarded.
- Addresses with the strap bit flipped, plus transfers cut short by a STOP. These separate correct decoding from an engine that answers too eagerly or stores partial bytes.

The power enables are walked through each single-term change around their off condition, so that each term of the decode is tested on its own.

// File: rtl/tir_pkg.sv
package tir_pkg;
    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR,
        S_ACK_ADR,
        S_PTR,
        S_ACK_PTR,
        S_WR,
        S_ACK_WR,
        S_RD,
        S_MACK
    } bus_state_t;
endpackage

// File: rtl/tir_line_sync.sv
module tir_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    // Synchronizer chain plus one extra stage for edge detection.
    logic [STAGES:0] scl_p, sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= '1;
            sda_p <= '1;
        end else begin
            scl_p <= {scl_p[STAGES-1:0], scl_i};
            sda_p <= {sda_p[STAGES-1:0], sda_i};
        end
    end

    assign scl_s     = scl_p[STAGES-1];
    assign sda_s     = sda_p[STAGES-1];
    assign scl_rise  = scl_p[STAGES-1] & ~scl_p[STAGES];
    assign scl_fall  = ~scl_p[STAGES-1] & scl_p[STAGES];
    assign start_det = scl_p[STAGES-1] & scl_p[STAGES] & sda_p[STAGES] & ~sda_p[STAGES-1];
    assign stop_det  = scl_p[STAGES-1] & scl_p[STAGES] & ~sda_p[STAGES] & sda_p[STAGES-1];
endmodule

// File: rtl/tir_serial_fsm.sv
module tir_serial_fsm
    import tir_pkg::*;
#(
    parameter int         DW      = 8,
    parameter int         PTR_W   = 4,
    parameter logic [4:0] ADDR_HI = 5'b11000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sda_s,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic             addr_strap,
    input  logic [DW-1:0]    rd_data,
    output logic [PTR_W-1:0] ptr,
    output logic             wr_en,
    output logic [DW-1:0]    wr_data,
    output logic             sda_oe,
    output logic             idle
);
    localparam int CNT_W = $clog2(DW + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DW);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DW - 1);

    bus_state_t       state;
    logic [CNT_W-1:0] cnt;
    logic [DW-1:0]    shreg;
    logic             rw;
    logic             mack_n;
    logic [6:0]       dev_addr;

    assign dev_addr = {ADDR_HI, addr_strap, 1'b0};

    // State register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            cnt    <= '0;
            shreg  <= '0;
            ptr    <= '0;
            rw     <= 1'b0;
            mack_n <= 1'b1;
        end else if (start_det) begin
            state <= S_ADDR;
            cnt   <= '0;
        end else if (stop_det) begin
            state <= S_IDLE;
            cnt   <= '0;
        end else begin
            unique case (state)
                S_IDLE: ;
                S_ADDR, S_PTR, S_WR: begin
                    if (scl_rise && cnt != FULL) begin
                        shreg <= {shreg[DW-2:0], sda_s};
                        cnt   <= cnt + 1'b1;
                    end else if (scl_fall && cnt == FULL) begin
                        cnt <= '0;
                        if (state == S_ADDR) begin
                            rw    <= shreg[0];
                            state <= (shreg[DW-1:1] == dev_addr) ? S_ACK_ADR : S_IDLE;
                        end else if (state == S_PTR) begin
                            ptr   <= shreg[PTR_W-1:0];
                            state <= S_ACK_PTR;
                        end else begin
                            ptr   <= ptr + 1'b1;
                            state <= S_ACK_WR;
                        end
                    end
                end
                S_ACK_ADR: begin
                    if (scl_fall) begin
                        if (rw) begin
                            state <= S_RD;
                            shreg <= rd_data;
                            ptr   <= ptr + 1'b1;
                            cnt   <= '0;
                        end else begin
                            state <= S_PTR;
                        end
                    end
                end
                S_ACK_PTR, S_ACK_WR: begin
                    if (scl_fall) state <= S_WR;
                end
                S_RD: begin
                    if (scl_fall) begin
                        if (cnt == LAST) begin
                            state <= S_MACK;
                            cnt   <= '0;
                        end else begin
                            shreg <= {shreg[DW-2:0], 1'b1};
                            cnt   <= cnt + 1'b1;
                        end
                    end
                end
                S_MACK: begin
                    if (scl_rise) begin
                        mack_n <= sda_s;
                    end else if (scl_fall) begin
                        if (!mack_n) begin
                            state <= S_RD;
                            shreg <= rd_data;
                            ptr   <= ptr + 1'b1;
                        end else begin
                            state <= S_IDLE;
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        sda_oe  = 1'b0;
        wr_en   = 1'b0;
        wr_data = shreg;
        idle    = (state == S_IDLE);
        unique case (state)
            S_ACK_ADR, S_ACK_PTR, S_ACK_WR: sda_oe = 1'b1;
            S_RD:   sda_oe = ~shreg[DW-1];
            S_WR:   wr_en  = scl_fall && (cnt == FULL) && !start_det && !stop_det;
            default: ;
        endcase
    end
endmodule

// File: rtl/tir_regfile.sv
module tir_regfile #(
    parameter int DW    = 8,
    parameter int N_RW  = 13,
    parameter int N_RO  = 3,
    parameter int PTR_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [PTR_W-1:0]   ptr,
    input  logic [DW-1:0]      wr_data,
    input  logic [N_RO*DW-1:0] ro_status,
    output logic [DW-1:0]      rd_data,
    output logic [N_RW*DW-1:0] regs_flat
);
    for (genvar k = 0; k < N_RW; k++) begin : g_reg
        logic [DW-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q <= '0;
            else if (wr_en && ptr == PTR_W'(k))
                q <= wr_data;
        end
        assign regs_flat[k*DW +: DW] = q;
    end

    // Pointers past the writable range select a status byte.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < N_RW; i++)
            if (ptr == PTR_W'(i)) rd_data = regs_flat[i*DW +: DW];
        for (int j = 0; j < N_RO; j++)
            if (ptr == PTR_W'(N_RW + j)) rd_data = ro_status[j*DW +: DW];
    end
endmodule

// File: rtl/tir_power_decode.sv
module tir_power_decode #(
    parameter int DW       = 8,
    parameter int SYN_BIT  = 4,
    parameter int REF_BIT  = 5,
    parameter int SHDN_NB  = 6,
    parameter int VCO_LSB  = 6,
    parameter int MODE_LSB = 0
) (
    input  logic [DW-1:0] shdn_reg,
    input  logic [DW-1:0] vco_reg,
    input  logic [DW-1:0] dco_reg,
    output logic          xtal_en,
    output logic          bias_en
);
    logic all_shut, vco_off, dco_off;

    assign all_shut = &shdn_reg[SHDN_NB-1:0];
    assign vco_off  = (vco_reg[VCO_LSB +: 2] == 2'b00);
    assign dco_off  = (dco_reg[MODE_LSB +: 2] == 2'b00);
    assign xtal_en  = ~(shdn_reg[SYN_BIT] & shdn_reg[REF_BIT]);
    assign bias_en  = ~(all_shut & vco_off & dco_off);
endmodule

// File: rtl/tuner_i2c_regbank.sv
module tuner_i2c_regbank #(
    parameter int DW       = 8,
    parameter int N_RW     = 13,
    parameter int N_RO     = 3,
    parameter int SHDN_IDX = 8,
    parameter int VCO_IDX  = 9,
    parameter int DCO_IDX  = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe,
    input  logic               addr_strap,
    input  logic [N_RO*DW-1:0] ro_status,
    output logic [N_RW*DW-1:0] regs_flat,
    output logic               xtal_en,
    output logic               bias_en
);
    localparam int PTR_W = $clog2(N_RW + N_RO);

    logic             scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [PTR_W-1:0] ptr;
    logic             wr_en, fsm_idle;
    logic [DW-1:0]    wr_data, rd_data;

    tir_line_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    tir_serial_fsm #(.DW(DW), .PTR_W(PTR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .addr_strap(addr_strap), .rd_data(rd_data), .ptr(ptr), .wr_en(wr_en),
        .wr_data(wr_data), .sda_oe(sda_oe), .idle(fsm_idle)
    );

    tir_regfile #(.DW(DW), .N_RW(N_RW), .N_RO(N_RO), .PTR_W(PTR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .ptr(ptr), .wr_data(wr_data),
        .ro_status(ro_status), .rd_data(rd_data), .regs_flat(regs_flat)
    );

    tir_power_decode #(.DW(DW)) u_pwr (
        .shdn_reg(regs_flat[SHDN_IDX*DW +: DW]),
        .vco_reg (regs_flat[VCO_IDX*DW +: DW]),
        .dco_reg (regs_flat[DCO_IDX*DW +: DW]),
        .xtal_en(xtal_en), .bias_en(bias_en)
    );
endmodule

// File: rtl/tir_regbank_checker.sv
module tir_regbank_checker #(
    parameter int DW       = 8,
    parameter int N_RW     = 13,
    parameter int SHDN_IDX = 8,
    parameter int VCO_IDX  = 9,
    parameter int DCO_IDX  = 11
) (
    input logic               clk,
    input logic               rst_n,
    input logic               scl_s,
    input logic               start_det,
    input logic               stop_det,
    input logic               fsm_idle,
    input logic               sda_oe,
    input logic [N_RW*DW-1:0] regs_flat,
    input logic               xtal_en,
    input logic               bias_en
);
    logic [DW-1:0] shdn, vco, dco;
    assign shdn = regs_flat[SHDN_IDX*DW +: DW];
    assign vco  = regs_flat[VCO_IDX*DW +: DW];
    assign dco  = regs_flat[DCO_IDX*DW +: DW];

    assert_xtal_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !xtal_en |-> (shdn[4] && shdn[5]));

    assert_bias_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bias_en |-> ((&shdn[5:0]) && vco[7:6] == 2'b00 && dco[1:0] == 2'b00));

    assert_sda_on_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_oe) && !start_det && !stop_det && !$past(start_det) && !$past(stop_det))
        |-> !scl_s);

    assert_regs_on_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(regs_flat) |-> !scl_s);

    assert_idle_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_idle |-> !sda_oe);

    assert_stop_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det && !start_det |=> fsm_idle);
endmodule

bind tuner_i2c_regbank tir_regbank_checker #(
    .DW(DW), .N_RW(N_RW), .SHDN_IDX(SHDN_IDX), .VCO_IDX(VCO_IDX), .DCO_IDX(DCO_IDX)
) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_det(start_det),
    .stop_det(stop_det), .fsm_idle(fsm_idle), .sda_oe(sda_oe),
    .regs_flat(regs_flat), .xtal_en(xtal_en), .bias_en(bias_en)
);

// File: tb/tb_tuner_i2c_regbank.sv
module tb_tuner_i2c_regbank;
    localparam int Q = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         scl_m = 1'b1;
    logic         sda_m = 1'b1;
    logic         strap = 1'b0;
    logic [23:0]  ro_status = 24'hC3B2A1;
    logic         sda_oe, xtal_en, bias_en;
    logic [103:0] regs_flat;
    logic         sda_line;
    int           n_cmp = 0;
    int           n_err = 0;
    bit           done = 1'b0;

    always #2 clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    tuner_i2c_regbank dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
        .addr_strap(strap), .ro_status(ro_status), .regs_flat(regs_flat),
        .xtal_en(xtal_en), .bias_en(bias_en)
    );

    // Single-register write/read vectors: {pointer, data}
    localparam logic [15:0] VEC [6] = '{16'h005A, 16'h01A5, 16'h04FF, 16'h0700, 16'h0A3C, 16'h0C81};

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic bit_out(input logic b);
        sda_m = b;    tick(Q);
        scl_m = 1'b1; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bit_in(output logic b);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q/2);
        b = sda_line; tick(Q/2);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic a;
        for (int i = 7; i >= 0; i--) bit_out(d[i]);
        bit_in(a);
        ack = ~a;
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) bit_in(d[i]);
        bit_out(nack);
    endtask

    function automatic logic [7:0] dev(input logic s, input logic rd);
        return {5'b11000, s, 1'b0, rd};
    endfunction

    // Write one byte; acks reports whether all three bytes were acknowledged
    task automatic wr1(input logic [7:0] p, input logic [7:0] d, output logic acks);
        logic a0, a1, a2;
        bus_start();
        send_byte(dev(strap, 1'b0), a0);
        send_byte(p, a1);
        send_byte(d, a2);
        bus_stop();
        acks = a0 & a1 & a2;
    endtask

    task automatic rd1(input logic [7:0] p, output logic [7:0] d);
        logic a;
        bus_start();
        send_byte(dev(strap, 1'b0), a);
        send_byte(p, a);
        bus_start();
        send_byte(dev(strap, 1'b1), a);
        recv_byte(1'b1, d);
        bus_stop();
    endtask

    function automatic logic [7:0] reg_of(input int k);
        return regs_flat[k*8 +: 8];
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_cmp++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
            $finish;
        end
    end

    initial begin
        logic       ok, a;
        logic [7:0] d, d1, d2;

        tick(5);
        // R8: reset state
        check("R8 regs", {31'b0, regs_flat == '0}, 32'd1);
        check("R8 sda_oe", {31'b0, sda_oe}, 32'd0);
        check("R8 xtal_en", {31'b0, xtal_en}, 32'd1);
        check("R8 bias_en", {31'b0, bias_en}, 32'd1);
        rst_n = 1'b1;
        tick(5);

        // R1 R3 R4: vector table
        foreach (VEC[i]) begin
            wr1(VEC[i][15:8], VEC[i][7:0], ok);
            check("R1 R3 acks", {31'b0, ok}, 32'd1);
            check("R3 stored", {24'b0, reg_of(int'(VEC[i][15:8]))}, {24'b0, VEC[i][7:0]});
            rd1(VEC[i][15:8], d);
            check("R4 readback", {24'b0, d}, {24'b0, VEC[i][7:0]});
        end

        // R3: burst write with auto-increment
        bus_start();
        send_byte(dev(strap, 1'b0), a);
        send_byte(8'h02, a);
        send_byte(8'h11, a);
        send_byte(8'h22, a);
        send_byte(8'h33, a);
        check("R3 burst ack", {31'b0, a}, 32'd1);
        bus_stop();
        check("R3 burst r2", {24'b0, reg_of(2)}, 32'h11);
        check("R3 burst r3", {24'b0, reg_of(3)}, 32'h22);
        check("R3 burst r4", {24'b0, reg_of(4)}, 32'h33);

        // R4: burst read with ACK, ACK, NACK
        bus_start();
        send_byte(dev(strap, 1'b0), a);
        send_byte(8'h02, a);
        bus_start();
        send_byte(dev(strap, 1'b1), a);
        recv_byte(1'b0, d);
        recv_byte(1'b0, d1);
        recv_byte(1'b1, d2);
        check("R4 burst b0", {24'b0, d}, 32'h11);
        check("R4 burst b1", {24'b0, d1}, 32'h22);
        check("R4 burst b2", {24'b0, d2}, 32'h33);
        check("R4 released after NACK", {31'b0, sda_oe}, 32'd0);
        bus_stop();

        // R5: status bytes and discarded writes
        bus_start();
        send_byte(dev(strap, 1'b0), a);
        send_byte(8'h0D, a);
        bus_start();
        send_byte(dev(strap, 1'b1), a);
        recv_byte(1'b0, d);
        recv_byte(1'b0, d1);
        recv_byte(1'b1, d2);
        bus_stop();
        check("R5 status0", {24'b0, d}, 32'hA1);
        check("R5 status1", {24'b0, d1}, 32'hB2);
        check("R5 status2", {24'b0, d2}, 32'hC3);
        wr1(8'h0E, 8'hFF, ok);
        check("R5 ro write acked", {31'b0, ok}, 32'd1);
        rd1(8'h0E, d);
        check("R5 ro unchanged", {24'b0, d}, 32'hB2);
        check("R5 r12 untouched", {24'b0, reg_of(12)}, 32'h81);

        // R6: wrap on read and on write
        bus_start();
        send_byte(dev(strap, 1'b0), a);
        send_byte(8'h0F, a);
        bus_start();
        send_byte(dev(strap, 1'b1), a);
        recv_byte(1'b0, d);
        recv_byte(1'b1, d1);
        bus_stop();
        check("R6 read wrap", {24'b0, d1}, 32'h5A);
        bus_start();
        send_byte(dev(strap, 1'b0), a);
        send_byte(8'h0F, a);
        send_byte(8'h99, a);
        send_byte(8'h66, a);
        bus_stop();
        check("R6 write wrap", {24'b0, reg_of(0)}, 32'h66);

        // R2: wrong address is ignored
        bus_start();
        send_byte(dev(~strap, 1'b0), a);
        check("R2 no ack", {31'b0, a}, 32'd0);
        send_byte(8'h01, a);
        send_byte(8'hEE, a);
        bus_stop();
        check("R2 reg unchanged", {24'b0, reg_of(1)}, 32'hA5);

        // R1: strap selects the address
        strap = 1'b1;
        wr1(8'h05, 8'h77, ok);
        check("R1 strap ack", {31'b0, ok}, 32'd1);
        check("R1 strap write", {24'b0, reg_of(5)}, 32'h77);
        bus_start();
        send_byte(dev(1'b0, 1'b0), a);
        check("R1 old addr nack", {31'b0, a}, 32'd0);
        bus_stop();

        // R7: STOP in the middle of a data byte
        bus_start();
        send_byte(dev(strap, 1'b0), a);
        send_byte(8'h06, a);
        for (int i = 0; i < 4; i++) bit_out(1'b1);
        bus_stop();
        check("R7 partial dropped", {24'b0, reg_of(6)}, 32'h00);
        check("R7 released", {31'b0, sda_oe}, 32'd0);

        // R9: crystal enable
        wr1(8'h09, 8'h00, ok);
        wr1(8'h0B, 8'h00, ok);
        wr1(8'h08, 8'h10, ok);
        check("R9 syn only", {31'b0, xtal_en}, 32'd1);
        wr1(8'h08, 8'h30, ok);
        check("R9 both off", {31'b0, xtal_en}, 32'd0);
        wr1(8'h08, 8'h20, ok);
        check("R9 ref only", {31'b0, xtal_en}, 32'd1);

        // R10: main bias enable
        wr1(8'h08, 8'h3F, ok);
        check("R10 all off", {31'b0, bias_en}, 32'd0);
        wr1(8'h09, 8'h40, ok);
        check("R10 vco on", {31'b0, bias_en}, 32'd1);
        wr1(8'h09, 8'h00, ok);
        wr1(8'h0B, 8'h01, ok);
        check("R10 dco on", {31'b0, bias_en}, 32'd1);
        wr1(8'h0B, 8'h00, ok);
        wr1(8'h08, 8'h1F, ok);
        check("R10 ref on", {31'b0, bias_en}, 32'd1);
        wr1(8'h08, 8'h3E, ok);
        check("R10 pd on", {31'b0, bias_en}, 32'd1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end
endmodule